// File: doc/BRIEF.md
# Two-Round Iterative Cipher Sequencer

This block drives an iterative 128-bit block cipher core that applies two rounds, one odd and one even, in every clock cycle. A one-cycle start pulse begins an operation on a 128-bit block under a 256-bit user key. A level select chooses encryption or decryption. The block can add one key-expansion cycle, then runs the round cycles, steers the round-key selection, counts the cycles and raises a done flag once the result is valid. The real substitution and permutation layers are replaced by simple stand-in functions, so the sequencing can be checked against a behavioural model.

When the new-key strobe is high together with start, the first cycle expands the user key. The two substitution units of the round datapath are borrowed to turn the key's low half U = key[127:0] into Ur and its high half V = key[255:128] into Vr. Both results are stored. Later operations that leave the strobe low reuse the stored pair and skip the expansion cycle. The initial key addition is merged into the two-round datapath, so twelve rounds plus the initial key addition take seven cycles. In each cycle an even-indexed and an odd-indexed round key are delivered.

Top module: `tworound_cipher_seq`

## Requirements
- R1: While rst_n is low and after its release, done_o is 0 and data_o is all zeros until the first operation completes.
- R2: A start accepted with new_key_i low makes done_o rise exactly 7 cycles after the start edge, and done_o is low at the 6th cycle.
- R3: A start accepted with new_key_i high spends one expansion cycle first. done_o rises exactly 8 cycles after the start edge, and the stored pair becomes Ur = S1(U), Vr = S3(V).
- R4: With decrypt_i low, data_o = x12, where x0 = D ^ K(0) and, for r = 1..12, xr = P(S(x(r-1))) ^ K(r). Odd r uses S3 and a 16-bit left rotation of the block; even r uses S1 and a 32-bit left rotation. S1 (S3) rotates every byte left by 1 (3) bits and XORs it with 0x63 (0x1D).
- R5: Encryption keys: for even r = 2c, K(r) = rotl(Ur, 8c) ^ rep(C(r) ^ 0x0F0F0F0F). For odd r = 2c+1, K(r) = rotl(Vr, 24*max(c-1,0)) ^ rep(C(r) ^ 0xF0F0F0F0). C(j) = (j+1)*0x9E3779B9 mod 2^32, and rep repeats the 32-bit word four times.
- R6: With decrypt_i high for the whole operation, K(r) uses the same layout as R5 but takes Vr for even r and Ur for odd r. It rotates right instead of left and uses constant C(12-r). The round sequence of R4 is unchanged.
- R7: With new_key_i low, key_i has no effect; the previously stored expanded pair is used.
- R8: start_i is ignored while an operation runs. The running result and its timing are unchanged, even when the ignored pulse carries new data, a new key and new_key_i high.
- R9: done_o drops in the cycle after an accepted start. Otherwise done_o stays high and data_o stays stable until the next accepted start, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle operation start pulse |
| decrypt_i | input | 1 | High for decryption, held for the whole operation |
| new_key_i | input | 1 | With start_i: expand key_i before the rounds |
| data_i | input | 128 | Input block, held until the first round cycle has passed |
| key_i | input | 256 | User key, held through the expansion cycle |
| data_o | output | 128 | Result block, valid while done_o is high |
| done_o | output | 1 | Result valid flag |

## Verification
The bench sweeps the data patterns for both directions, with and without key expansion. It compares every result with a model that first builds the whole key list and then applies thirteen separate rounds. A design that paired the round keys wrongly, released the high expanded half one cycle early, or swapped the decryption halves would produce a wrong block. The bench also changes key_i without the strobe. A design that re-expanded the key anyway would give a result that depends on the new key. It pulses start with fresh data and a new key in the middle of a run and checks the unchanged result at the unchanged cycle. A controller that restarted would finish late or with the wrong block. Finally it holds the idle block under changing inputs and checks that a spurious write would show up on data_o.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;
  localparam int unsigned BLK_W       = 128;
  localparam int unsigned KEY_W       = 2 * BLK_W;
  localparam int unsigned NUM_ROUNDS  = 12;
  localparam int unsigned PAIR_CYCLES = NUM_ROUNDS / 2 + 1;
  localparam int unsigned CNT_W       = $clog2(PAIR_CYCLES);
  localparam int unsigned IDX_W       = $clog2(NUM_ROUNDS + 1);
  localparam int unsigned RC_W        = 32;
  localparam int unsigned LANES       = BLK_W / RC_W;
  localparam int unsigned NBYTES      = BLK_W / 8;

  localparam int unsigned SUB_E_ROT   = 1;
  localparam int unsigned SUB_O_ROT   = 3;
  localparam logic [7:0]  SUB_E_XOR   = 8'h63;
  localparam logic [7:0]  SUB_O_XOR   = 8'h1D;
  localparam int unsigned PERM_E_ROT  = 32;
  localparam int unsigned PERM_O_ROT  = 16;
  localparam int unsigned UPD_LO_ROT  = 8;
  localparam int unsigned UPD_HI_ROT  = 24;
  localparam logic [RC_W-1:0] RC_SEED = 32'h9E3779B9;
  localparam logic [RC_W-1:0] MASK_E  = 32'h0F0F0F0F;
  localparam logic [RC_W-1:0] MASK_O  = 32'hF0F0F0F0;

  typedef logic [BLK_W-1:0] blk_t;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef enum logic [1:0] {PH_IDLE, PH_EXPAND, PH_ROUND} phase_e;

  function automatic blk_t rotl_blk(input blk_t x, input int unsigned n);
    return (x << n) | (x >> (BLK_W - n));
  endfunction

  function automatic blk_t rotr_blk(input blk_t x, input int unsigned n);
    return (x >> n) | (x << (BLK_W - n));
  endfunction

  function automatic blk_t sub_lanes(input blk_t x, input int unsigned r,
                                     input logic [7:0] c);
    blk_t y;
    logic [7:0] b;
    for (int i = 0; i < NBYTES; i++) begin
      b = x[i*8 +: 8];
      y[i*8 +: 8] = ((b << r) | (b >> (8 - r))) ^ c;
    end
    return y;
  endfunction

  function automatic blk_t sub_even(input blk_t x);
    return sub_lanes(x, SUB_E_ROT, SUB_E_XOR);
  endfunction

  function automatic blk_t sub_odd(input blk_t x);
    return sub_lanes(x, SUB_O_ROT, SUB_O_XOR);
  endfunction

  function automatic blk_t perm_even(input blk_t x);
    return rotl_blk(x, PERM_E_ROT);
  endfunction

  function automatic blk_t perm_odd(input blk_t x);
    return rotl_blk(x, PERM_O_ROT);
  endfunction

  function automatic logic [RC_W-1:0] round_const(input logic [IDX_W-1:0] idx);
    logic [RC_W-1:0] p;
    p = (RC_W'(idx) + 32'd1) * RC_SEED;
    return p;
  endfunction

  function automatic logic [IDX_W-1:0] key_index(input cnt_t rnd, input logic odd,
                                                 input logic dec);
    int j;
    j = 2 * int'(rnd) + int'(odd);
    if (dec) j = int'(NUM_ROUNDS) - j;
    return IDX_W'(j);
  endfunction

  function automatic blk_t splat(input logic [RC_W-1:0] w);
    return {LANES{w}};
  endfunction
endpackage

// File: rtl/trc_ctrl.sv
`timescale 1ns/1ps
module trc_ctrl
  import trc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic new_key_i,
  output logic busy_o,
  output logic accept_o,
  output logic cyc0_o,
  output logic cyc1_o,
  output logic adv_o,
  output logic last_o,
  output cnt_t round_o,
  output logic done_o
);
  localparam cnt_t LAST_CNT = cnt_t'(PAIR_CYCLES - 1);

  phase_e phase_q;
  cnt_t   cnt_q;
  logic   done_q;

  assign busy_o   = (phase_q != PH_IDLE);
  assign accept_o = start_i && !busy_o;
  assign cyc0_o   = (phase_q == PH_EXPAND);
  assign adv_o    = (phase_q == PH_ROUND);
  assign cyc1_o   = adv_o && (cnt_q == '0);
  assign last_o   = adv_o && (cnt_q == LAST_CNT);
  assign round_o  = cnt_q;
  assign done_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (accept_o) begin
            phase_q <= new_key_i ? PH_EXPAND : PH_ROUND;
            cnt_q   <= '0;
            done_q  <= 1'b0;
          end
        end
        PH_EXPAND: begin
          phase_q <= PH_ROUND;
          cnt_q   <= '0;
        end
        PH_ROUND: begin
          if (cnt_q == LAST_CNT) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + cnt_t'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trc_keysched.sv
`timescale 1ns/1ps
module trc_keysched
  import trc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic decrypt_i,
  input  logic cyc0_i,
  input  logic adv_i,
  input  cnt_t round_i,
  input  blk_t fresh_lo_i,
  input  blk_t fresh_hi_i,
  output blk_t exp_lo_o,
  output blk_t exp_hi_o,
  output blk_t k_even_o,
  output blk_t k_odd_o
);
  blk_t exp_lo_q, exp_hi_q;
  blk_t run_lo_q, run_hi_q;
  blk_t base_lo, base_hi;
  blk_t sel_lo, sel_hi;
  blk_t nxt_lo_enc, nxt_lo_dec, nxt_hi_enc, nxt_hi_dec;
  blk_t k_even_enc, k_even_dec, k_odd_enc, k_odd_dec;
  logic hi_hold;

  assign exp_lo_o = exp_lo_q;
  assign exp_hi_o = exp_hi_q;

  // decryption swaps which stored half feeds which key lane
  assign base_lo = decrypt_i ? exp_hi_q : exp_lo_q;
  assign base_hi = decrypt_i ? exp_lo_q : exp_hi_q;

  // low lane is fresh only in the first cycle, high lane in the first two
  assign hi_hold = (round_i < cnt_t'(2));
  assign sel_lo  = (round_i == '0) ? base_lo : run_lo_q;
  assign sel_hi  = hi_hold ? base_hi : run_hi_q;

  assign nxt_lo_enc = rotl_blk(sel_lo, UPD_LO_ROT);
  assign nxt_lo_dec = rotr_blk(sel_lo, UPD_LO_ROT);
  assign nxt_hi_enc = rotl_blk(sel_hi, UPD_HI_ROT);
  assign nxt_hi_dec = rotr_blk(sel_hi, UPD_HI_ROT);

  assign k_even_enc = sel_lo ^ splat(round_const(key_index(round_i, 1'b0, 1'b0)) ^ MASK_E);
  assign k_even_dec = sel_lo ^ splat(round_const(key_index(round_i, 1'b0, 1'b1)) ^ MASK_E);
  assign k_odd_enc  = sel_hi ^ splat(round_const(key_index(round_i, 1'b1, 1'b0)) ^ MASK_O);
  assign k_odd_dec  = sel_hi ^ splat(round_const(key_index(round_i, 1'b1, 1'b1)) ^ MASK_O);

  assign k_even_o = decrypt_i ? k_even_dec : k_even_enc;
  assign k_odd_o  = decrypt_i ? k_odd_dec  : k_odd_enc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_lo_q <= '0;
      exp_hi_q <= '0;
    end else if (cyc0_i) begin
      exp_lo_q <= fresh_lo_i;
      exp_hi_q <= fresh_hi_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_lo_q <= '0;
      run_hi_q <= '0;
    end else if (adv_i) begin
      run_lo_q <= decrypt_i ? nxt_lo_dec : nxt_lo_enc;
      if (round_i != '0) run_hi_q <= decrypt_i ? nxt_hi_dec : nxt_hi_enc;
    end
  end
endmodule

// File: rtl/trc_datapath.sv
`timescale 1ns/1ps
module trc_datapath
  import trc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc0_i,
  input  logic             cyc1_i,
  input  logic             adv_i,
  input  logic             last_i,
  input  blk_t             data_i,
  input  logic [KEY_W-1:0] key_i,
  input  blk_t             k_even_i,
  input  blk_t             k_odd_i,
  output blk_t             fresh_lo_o,
  output blk_t             fresh_hi_o,
  output blk_t             data_o
);
  blk_t x_q, out_q;
  blk_t x_in, t_even, t_odd, so_in, so_out, se_in, se_out, x_nxt;

  assign x_in   = cyc1_i ? data_i : x_q;
  assign t_even = x_in ^ k_even_i;

  // substitution units are shared with key expansion during the expand cycle
  assign so_in  = cyc0_i ? key_i[KEY_W-1:BLK_W] : t_even;
  assign so_out = sub_odd(so_in);
  assign t_odd  = perm_odd(so_out) ^ k_odd_i;
  assign se_in  = cyc0_i ? key_i[BLK_W-1:0] : t_odd;
  assign se_out = sub_even(se_in);
  assign x_nxt  = perm_even(se_out);

  assign fresh_lo_o = se_out;
  assign fresh_hi_o = so_out;
  assign data_o     = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      out_q <= '0;
    end else if (adv_i) begin
      if (last_i) out_q <= t_even;
      else        x_q   <= x_nxt;
    end
  end
endmodule

// File: rtl/tworound_cipher_seq.sv
`timescale 1ns/1ps
module tworound_cipher_seq
  import trc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         decrypt_i,
  input  logic         new_key_i,
  input  logic [127:0] data_i,
  input  logic [255:0] key_i,
  output logic [127:0] data_o,
  output logic         done_o
);
  logic busy, accept, cyc0, cyc1, adv, last;
  cnt_t round;
  blk_t fresh_lo, fresh_hi, exp_lo, exp_hi, k_even, k_odd;

  trc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .new_key_i(new_key_i),
    .busy_o(busy), .accept_o(accept), .cyc0_o(cyc0), .cyc1_o(cyc1),
    .adv_o(adv), .last_o(last), .round_o(round), .done_o(done_o)
  );

  trc_keysched u_keys (
    .clk(clk), .rst_n(rst_n), .decrypt_i(decrypt_i), .cyc0_i(cyc0),
    .adv_i(adv), .round_i(round), .fresh_lo_i(fresh_lo), .fresh_hi_i(fresh_hi),
    .exp_lo_o(exp_lo), .exp_hi_o(exp_hi), .k_even_o(k_even), .k_odd_o(k_odd)
  );

  trc_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .cyc0_i(cyc0), .cyc1_i(cyc1), .adv_i(adv),
    .last_i(last), .data_i(data_i), .key_i(key_i), .k_even_i(k_even),
    .k_odd_i(k_odd), .fresh_lo_o(fresh_lo), .fresh_hi_o(fresh_hi),
    .data_o(data_o)
  );
endmodule

// File: rtl/trc_checker.sv
`timescale 1ns/1ps
module trc_checker
  import trc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy,
  input logic cyc0,
  input logic cyc1,
  input logic last,
  input cnt_t round,
  input logic done_o,
  input blk_t data_o,
  input blk_t exp_lo,
  input blk_t exp_hi
);
  a_r3_expand_then_first: assert property (@(posedge clk) disable iff (!rst_n)
    cyc0 |=> cyc1);

  a_r2_round_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc0 && !last) |=> (round == cnt_t'($past(round) + cnt_t'(1))));

  a_r2_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(last));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy && !cyc0 && !last) |=> (!cyc0 && !cyc1));

  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(data_o)));

  a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy);

  a_r7_expkey_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc0 |=> ($stable(exp_lo) && $stable(exp_hi)));
endmodule

bind tworound_cipher_seq trc_checker u_trc_checker (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy), .cyc0(cyc0),
  .cyc1(cyc1), .last(last), .round(round), .done_o(done_o), .data_o(data_o),
  .exp_lo(exp_lo), .exp_hi(exp_hi)
);

// File: tb/test_tworound_cipher_seq.sv
`timescale 1ns/1ps
module test_tworound_cipher_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0, decrypt_i = 1'b0, new_key_i = 1'b0;
  logic [127:0] data_i = '0;
  logic [255:0] key_i = '0;
  logic [127:0] data_o;
  logic         done_o;

  int checks = 0;
  int fails  = 0;
  logic [127:0] m_ur = '0, m_vr = '0;

  always #10 clk = ~clk;

  tworound_cipher_seq i_tworound_cipher_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .decrypt_i(decrypt_i),
    .new_key_i(new_key_i), .data_i(data_i), .key_i(key_i),
    .data_o(data_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] b_rotl(input logic [127:0] x, input int n);
    int s;
    s = n % 128;
    if (s == 0) return x;
    return (x << s) | (x >> (128 - s));
  endfunction

  function automatic logic [127:0] b_rotr(input logic [127:0] x, input int n);
    return b_rotl(x, (128 - (n % 128)) % 128);
  endfunction

  function automatic logic [127:0] b_sub(input logic [127:0] x, input int r,
                                         input logic [7:0] c);
    logic [127:0] y;
    logic [7:0] b, hi, lo;
    for (int i = 0; i < 16; i++) begin
      b  = x[i*8 +: 8];
      hi = b << r;
      lo = b >> (8 - r);
      y[i*8 +: 8] = (hi | lo) ^ c;
    end
    return y;
  endfunction

  function automatic logic [31:0] b_rc(input int j);
    logic [31:0] v;
    v = '0;
    for (int k = 0; k <= j; k++) v = v + 32'h9E3779B9;
    return v;
  endfunction

  function automatic logic [127:0] b_key(input int r, input bit dec,
                                         input logic [127:0] ur, input logic [127:0] vr);
    int c, s, j;
    logic [31:0] w;
    j = dec ? 12 - r : r;
    if (r % 2 == 0) begin
      c = r / 2;
      w = b_rc(j) ^ 32'h0F0F0F0F;
      return (dec ? b_rotr(vr, 8 * c) : b_rotl(ur, 8 * c)) ^ {4{w}};
    end
    c = (r - 1) / 2;
    s = (c > 1) ? c - 1 : 0;
    w = b_rc(j) ^ 32'hF0F0F0F0;
    return (dec ? b_rotr(ur, 24 * s) : b_rotl(vr, 24 * s)) ^ {4{w}};
  endfunction

  function automatic logic [127:0] b_model(input logic [127:0] d, input bit dec,
                                           input logic [127:0] ur, input logic [127:0] vr);
    logic [127:0] x;
    x = d ^ b_key(0, dec, ur, vr);
    for (int r = 1; r <= 12; r++) begin
      if (r % 2 == 1) x = b_rotl(b_sub(x, 3, 8'h1D), 16);
      else            x = b_rotl(b_sub(x, 1, 8'h63), 32);
      x = x ^ b_key(r, dec, ur, vr);
    end
    return x;
  endfunction

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // R2/R3 latency, R4/R5/R6 value (tag), R8 ignored start when poke is set
  task automatic run_op(input logic [127:0] d, input logic [255:0] k, input bit dec,
                        input bit nk, input bit poke, input string tag);
    int lat;
    logic [127:0] exp;
    string ltag;
    lat  = nk ? 8 : 7;
    ltag = nk ? "R3" : "R2";
    if (nk) begin
      m_ur = b_sub(k[127:0], 1, 8'h63);
      m_vr = b_sub(k[255:128], 3, 8'h1D);
    end
    exp = b_model(d, dec, m_ur, m_vr);
    @(negedge clk);
    data_i = d; key_i = k; decrypt_i = dec; new_key_i = nk; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; new_key_i = 1'b0;
    chk(done_o == 1'b0, "R9", "done after accepted start", 128'(done_o), 128'd0);
    for (int m = 2; m <= lat; m++) begin
      @(negedge clk);
      if (poke && m == 3) begin
        start_i = 1'b1; new_key_i = 1'b1; data_i = ~d; key_i = ~k;
      end
      if (poke && m == 4) begin
        start_i = 1'b0; new_key_i = 1'b0;
      end
    end
    chk(done_o == 1'b0, ltag, "done one cycle early", 128'(done_o), 128'd0);
    @(negedge clk);
    chk(done_o == 1'b1, poke ? "R8" : ltag, "done at latency", 128'(done_o), 128'd1);
    chk(data_o == exp, poke ? "R8" : tag, "result block", data_o, exp);
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [127:0] held;
    logic [255:0] ka, kb;
    logic [127:0] pats [6];
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = 128'h00112233445566778899AABBCCDDEEFF;
    pats[3] = 128'h80000000000000000000000000000001;
    pats[4] = {4{32'hDEADBEEF}};
    pats[5] = 128'h0123456789ABCDEFFEDCBA9876543210;
    ka = 256'h000102030405060708090A0B0C0D0E0F101112131415161718191A1B1C1D1E1F;
    kb = {8{32'hA5C3_1E77}};

    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R1", "done in reset", 128'(done_o), 128'd0);
    chk(data_o == '0, "R1", "data in reset", data_o, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done_o == 1'b0, "R1", "done after reset", 128'(done_o), 128'd0);
    chk(data_o == '0, "R1", "data after reset", data_o, '0);

    run_op(pats[2], ka, 1'b0, 1'b1, 1'b0, "R4");
    for (int p = 0; p < 6; p++) begin
      run_op(pats[p], ka, 1'b0, 1'b0, 1'b0, "R5");
      run_op(pats[p], ka, 1'b1, 1'b0, 1'b0, "R6");
    end
    // key changed without strobe: stored pair still in use
    run_op(pats[5], kb, 1'b0, 1'b0, 1'b0, "R7");
    run_op(pats[3], '1, 1'b1, 1'b0, 1'b0, "R7");
    run_op(pats[4], kb, 1'b1, 1'b1, 1'b0, "R6");
    run_op(pats[1], '0, 1'b0, 1'b1, 1'b0, "R3");
    run_op(pats[0], kb, 1'b0, 1'b0, 1'b0, "R4");
    run_op(pats[5], ka, 1'b0, 1'b1, 1'b1, "R8");
    run_op(pats[2], kb, 1'b1, 1'b0, 1'b1, "R8");

    held = data_o;
    for (int h = 0; h < 5; h++) begin
      @(negedge clk);
      data_i = ~data_i; key_i = ~key_i; decrypt_i = ~decrypt_i;
    end
    @(negedge clk);
    chk(done_o == 1'b1, "R9", "done held", 128'(done_o), 128'd1);
    chk(data_o == held, "R9", "data held", data_o, held);

    report();
    $finish;
  end
endmodule